// File: doc/BRIEF.md
# DMA Controller Register Bank and Interrupt Aggregator

This block is the bus-facing register bank of a multi-channel DMA controller. It decodes a 4 KB window of 32-bit words and holds the per-channel programming words: source address, destination address, link pointer to the next descriptor, control and configuration. It also holds the controller-wide configuration and synchronisation words. The transfer engine reads all of these through flat output buses. It reports progress back through one-cycle terminal-count and error pulses per channel.

The bank keeps a raw terminal-count bit and a raw error bit for each channel. Software clears them by writing ones to dedicated clear offsets. The interrupt masks are not registers of their own: each channel's two mask bits are taken live from its configuration word. A single level-sensitive interrupt is raised while any masked status bit is set. Writing a channel configuration word or the controller configuration word sends a one-cycle strobe to the engine. Identification bytes sit at the top of the window. Illegal accesses read as zero, change nothing, and set a sticky error flag.

Bus reads are combinational from the registered state. Writes take effect at the clock edge of the access cycle.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every register and status bit is zero, `irq` and `badFlag` are low, and every status offset reads zero.
- R2: Channel c's words sit at 0x100 + 0x20*c (channel = address bits 7:5). The slots are: source at +0x00, destination at +0x04, link at +0x08, control at +0x0C and configuration at +0x10. Each reads back what was written and appears on the matching slice c of the channel output buses.
- R3: A `tcEvent[c]` or `errEvent[c]` pulse sets raw bit c, read at 0x014 (terminal count) or 0x018 (error). Writing a value to 0x008 (terminal count) or 0x010 (error) clears the raw bits where the value has ones. An event and a clear on the same bit in the same cycle leave the bit set.
- R4: The terminal-count mask bit of channel c is bit 15 of its configuration word, and the error mask bit is bit 14. 0x004 reads masked terminal-count status, 0x00C reads masked error status, and 0x000 reads the OR of the two.
- R5: `irq` is high exactly while some masked terminal-count or masked error bit is set, and it follows a mask or status change with no added cycle.
- R6: 0x01C reads a bitmap with bit c set while bit 0 of channel c's configuration word is set.
- R7: 0x030 holds the controller configuration (bit 0 enable, bits 1 and 2 byte order) and drives `ctrlCfg`. 0x034 holds the sync word and drives `syncCfg`. The four words 0x020 to 0x02C read zero, and writes to them change nothing and are not flagged.
- R8: `cfgWrStrobe` is high for exactly the one cycle after a write to a channel configuration word or to 0x030, and stays low after other writes.
- R9: The words 0xFE0 to 0xFFC read one identification byte each, in address order: 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. When NUM_CHAN is 2 the first byte is 0x81.
- R10: Each of the following is a bad access: a channel index at or above NUM_CHAN, a channel slot above +0x10, an undefined offset, a write to a read-only offset, and a read of a clear offset. A bad access reads zero, writes nothing and sets `badFlag`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the window (word aligned) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (zero when not reading) |
| tcEvent | input | NUM_CHAN | Per-channel terminal-count pulse from the engine |
| errEvent | input | NUM_CHAN | Per-channel error pulse from the engine |
| chanSrc | output | 32*NUM_CHAN | Source words, channel c at bits 32c+31:32c |
| chanDst | output | 32*NUM_CHAN | Destination words |
| chanLink | output | 32*NUM_CHAN | Next-descriptor pointers |
| chanCtrl | output | 32*NUM_CHAN | Control words |
| chanCfg | output | 32*NUM_CHAN | Configuration words |
| ctrlCfg | output | 32 | Controller configuration word |
| syncCfg | output | 32 | Synchronisation word |
| cfgWrStrobe | output | 1 | One-cycle pulse after a configuration write |
| irq | output | 1 | Level interrupt |
| badFlag | output | 1 | Sticky bad-access flag |

## Verification
Two functions can act on the same status bit in the same cycle: an engine event that sets the bit and a software clear write that removes it. The bench drives the clear write to 0x008 with all ones together with a `tcEvent` pulse on a bit that is already set, and does this within a single cycle. It then expects that bit alone to survive in the raw status. The interrupt is also judged while a mask change and a status change overlap. The bench writes a configuration word that enables a mask over a bit that is already pending, and expects `irq` in the cycle after that write.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  typedef enum logic [3:0] {
    RD_ZERO, RD_STAT, RD_TCM, RD_ERRM, RD_TCRAW,
    RD_ERRRAW, RD_EN, RD_GCFG, RD_SYNC, RD_CHAN, RD_ID
  } rd_sel_e;

  // Strobes from decode control to the datapath
  typedef struct packed {
    logic [4:0] chanWr;   // one per channel slot
    logic       clrTc;
    logic       clrErr;
    logic       wrGcfg;
    logic       wrSync;
    logic       badHit;
    logic [2:0] chanIdx;
    logic [2:0] sub;      // slot / identification word
    rd_sel_e    rdSel;
  } csr_strobe_t;

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output csr_strobe_t       st
);

  logic [3:0] wordIdx;
  logic chanRegion, idRegion, globRegion, chanOk, slotOk, legal;

  always_comb begin
    st = '0;
    st.rdSel = RD_ZERO;
    st.chanIdx = busAddr[7:5];
    st.sub = busAddr[4:2];
    wordIdx = busAddr[5:2];
    chanRegion = (busAddr[11:8] == 4'h1);
    idRegion = (busAddr[11:5] == 7'h7F);
    globRegion = (busAddr[11:6] == 6'h00);
    chanOk = (32'(busAddr[7:5]) < NUM_CHAN);
    slotOk = (busAddr[4:2] <= 3'd4);
    legal = 1'b0;
    if (chanRegion && chanOk && slotOk) begin
      legal = 1'b1;
      if (busWr) begin
        case (busAddr[4:2])
          3'd0: st.chanWr[0] = 1'b1;
          3'd1: st.chanWr[1] = 1'b1;
          3'd2: st.chanWr[2] = 1'b1;
          3'd3: st.chanWr[3] = 1'b1;
          default: st.chanWr[4] = 1'b1;
        endcase
      end else begin
        st.rdSel = RD_CHAN;
      end
    end else if (idRegion) begin
      legal = !busWr;
      st.rdSel = RD_ID;
    end else if (globRegion) begin
      if (busWr) begin
        legal = 1'b1;
        case (wordIdx)
          4'd2: st.clrTc = 1'b1;
          4'd4: st.clrErr = 1'b1;
          4'd8, 4'd9, 4'd10, 4'd11: ;
          4'd12: st.wrGcfg = 1'b1;
          4'd13: st.wrSync = 1'b1;
          default: legal = 1'b0;
        endcase
      end else begin
        legal = 1'b1;
        case (wordIdx)
          4'd0: st.rdSel = RD_STAT;
          4'd1: st.rdSel = RD_TCM;
          4'd3: st.rdSel = RD_ERRM;
          4'd5: st.rdSel = RD_TCRAW;
          4'd6: st.rdSel = RD_ERRRAW;
          4'd7: st.rdSel = RD_EN;
          4'd8, 4'd9, 4'd10, 4'd11: st.rdSel = RD_ZERO;
          4'd12: st.rdSel = RD_GCFG;
          4'd13: st.rdSel = RD_SYNC;
          default: legal = 1'b0;
        endcase
      end
    end
    if (!(busSel && busWr)) begin
      st.chanWr = '0;
      st.clrTc = 1'b0;
      st.clrErr = 1'b0;
      st.wrGcfg = 1'b0;
      st.wrSync = 1'b0;
    end
    if (!legal) st.rdSel = RD_ZERO;
    st.badHit = busSel && !legal;
  end

endmodule

// File: rtl/dma_csr_data.sv
module dma_csr_data
  import dma_csr_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rdEn,
  input  csr_strobe_t                st,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic [NUM_CHAN-1:0]        tcEvent,
  input  logic [NUM_CHAN-1:0]        errEvent,
  output logic [NUM_CHAN*DATA_W-1:0] chanSrc,
  output logic [NUM_CHAN*DATA_W-1:0] chanDst,
  output logic [NUM_CHAN*DATA_W-1:0] chanLink,
  output logic [NUM_CHAN*DATA_W-1:0] chanCtrl,
  output logic [NUM_CHAN*DATA_W-1:0] chanCfg,
  output logic [DATA_W-1:0]          ctrlCfg,
  output logic [DATA_W-1:0]          syncCfg,
  output logic                       cfgWrStrobe,
  output logic                       irq,
  output logic                       badFlag
);

  localparam int CW = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam int PAD = DATA_W - NUM_CHAN;
  localparam int TC_MASK_BIT = 15;
  localparam int ERR_MASK_BIT = 14;
  localparam logic [7:0] ID_FIRST = (NUM_CHAN == 2) ? 8'h81 : 8'h80;

  logic [DATA_W-1:0] srcQ [NUM_CHAN];
  logic [DATA_W-1:0] dstQ [NUM_CHAN];
  logic [DATA_W-1:0] linkQ [NUM_CHAN];
  logic [DATA_W-1:0] ctrlQ [NUM_CHAN];
  logic [DATA_W-1:0] cfgQ [NUM_CHAN];
  logic [NUM_CHAN-1:0] tcRaw, errRaw, tcMask, errMask, enMap;
  logic [CW-1:0] rIdx;

  function automatic logic [7:0] idByte(input logic [2:0] k);
    case (k)
      3'd0: idByte = ID_FIRST;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h0A;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic hit;
    assign hit = (st.chanIdx == 3'(c));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcQ[c] <= '0;
        dstQ[c] <= '0;
        linkQ[c] <= '0;
        ctrlQ[c] <= '0;
        cfgQ[c] <= '0;
      end else if (hit) begin
        if (st.chanWr[0]) srcQ[c] <= busWdata;
        if (st.chanWr[1]) dstQ[c] <= busWdata;
        if (st.chanWr[2]) linkQ[c] <= busWdata;
        if (st.chanWr[3]) ctrlQ[c] <= busWdata;
        if (st.chanWr[4]) cfgQ[c] <= busWdata;
      end
    end
    assign tcMask[c] = cfgQ[c][TC_MASK_BIT];
    assign errMask[c] = cfgQ[c][ERR_MASK_BIT];
    assign enMap[c] = cfgQ[c][0];
    assign chanSrc[c*DATA_W +: DATA_W] = srcQ[c];
    assign chanDst[c*DATA_W +: DATA_W] = dstQ[c];
    assign chanLink[c*DATA_W +: DATA_W] = linkQ[c];
    assign chanCtrl[c*DATA_W +: DATA_W] = ctrlQ[c];
    assign chanCfg[c*DATA_W +: DATA_W] = cfgQ[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcRaw <= '0;
      errRaw <= '0;
      ctrlCfg <= '0;
      syncCfg <= '0;
      cfgWrStrobe <= 1'b0;
      badFlag <= 1'b0;
    end else begin
      // set beats clear on the same bit
      tcRaw <= (tcRaw & ~(st.clrTc ? busWdata[NUM_CHAN-1:0] : '0)) | tcEvent;
      errRaw <= (errRaw & ~(st.clrErr ? busWdata[NUM_CHAN-1:0] : '0)) | errEvent;
      if (st.wrGcfg) ctrlCfg <= busWdata;
      if (st.wrSync) syncCfg <= busWdata;
      cfgWrStrobe <= st.chanWr[4] || st.wrGcfg;
      if (st.badHit) badFlag <= 1'b1;
    end
  end

  assign irq = |((tcRaw & tcMask) | (errRaw & errMask));
  assign rIdx = st.chanIdx[CW-1:0];

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (st.rdSel)
        RD_STAT:   busRdata = {{PAD{1'b0}}, (tcRaw & tcMask) | (errRaw & errMask)};
        RD_TCM:    busRdata = {{PAD{1'b0}}, tcRaw & tcMask};
        RD_ERRM:   busRdata = {{PAD{1'b0}}, errRaw & errMask};
        RD_TCRAW:  busRdata = {{PAD{1'b0}}, tcRaw};
        RD_ERRRAW: busRdata = {{PAD{1'b0}}, errRaw};
        RD_EN:     busRdata = {{PAD{1'b0}}, enMap};
        RD_GCFG:   busRdata = ctrlCfg;
        RD_SYNC:   busRdata = syncCfg;
        RD_ID:     busRdata = {{(DATA_W-8){1'b0}}, idByte(st.sub)};
        RD_CHAN: begin
          case (st.sub)
            3'd0: busRdata = srcQ[rIdx];
            3'd1: busRdata = dstQ[rIdx];
            3'd2: busRdata = linkQ[rIdx];
            3'd3: busRdata = ctrlQ[rIdx];
            default: busRdata = cfgQ[rIdx];
          endcase
        end
        default: busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic [NUM_CHAN-1:0]        tcEvent,
  input  logic [NUM_CHAN-1:0]        errEvent,
  output logic [NUM_CHAN*DATA_W-1:0] chanSrc,
  output logic [NUM_CHAN*DATA_W-1:0] chanDst,
  output logic [NUM_CHAN*DATA_W-1:0] chanLink,
  output logic [NUM_CHAN*DATA_W-1:0] chanCtrl,
  output logic [NUM_CHAN*DATA_W-1:0] chanCfg,
  output logic [DATA_W-1:0]          ctrlCfg,
  output logic [DATA_W-1:0]          syncCfg,
  output logic                       cfgWrStrobe,
  output logic                       irq,
  output logic                       badFlag
);

  csr_strobe_t st;

  dma_csr_ctrl #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .st(st)
  );

  dma_csr_data #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .rdEn(busSel && !busWr), .st(st),
    .busWdata(busWdata), .busRdata(busRdata),
    .tcEvent(tcEvent), .errEvent(errEvent),
    .chanSrc(chanSrc), .chanDst(chanDst), .chanLink(chanLink),
    .chanCtrl(chanCtrl), .chanCfg(chanCfg),
    .ctrlCfg(ctrlCfg), .syncCfg(syncCfg),
    .cfgWrStrobe(cfgWrStrobe), .irq(irq), .badFlag(badFlag)
  );

endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
  parameter int NUM_CHAN = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busSel,
  input logic                       busWr,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [DATA_W-1:0]          busRdata,
  input logic [NUM_CHAN-1:0]        tcEvent,
  input logic [NUM_CHAN*DATA_W-1:0] chanCfg,
  input logic                       cfgWrStrobe,
  input logic                       irq,
  input logic                       badFlag
);

  logic [NUM_CHAN-1:0] tcM, errM;
  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++) begin
      tcM[c] = chanCfg[c*DATA_W + 15];
      errM[c] = chanCfg[c*DATA_W + 14];
    end
  end

  a_r5_masked_event_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    (|(tcEvent & tcM)) |=> irq);

  a_r5_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    ((tcM == '0) && (errM == '0)) |-> !irq);

  a_r8_strobe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrStrobe |-> $past(busSel && busWr));

  a_r10_bad_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    badFlag |=> badFlag);

  a_r7_softreq_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr[11:4] == 8'h02) |-> (busRdata == '0));

endmodule

bind dma_csr_bank dma_csr_chk #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busRdata(busRdata), .tcEvent(tcEvent), .chanCfg(chanCfg),
  .cfgWrStrobe(cfgWrStrobe), .irq(irq), .badFlag(badFlag)
);

// File: tb/dma_csr_bank_bench.sv
module dma_csr_bank_bench;

  localparam int N = 8;
  localparam int N2 = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, selTwo = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdata, rdata2;
  logic [N-1:0] tcEvent = '0, errEvent = '0;
  logic [N*32-1:0] chanSrc, chanDst, chanLink, chanCtrl, chanCfg;
  logic [31:0] ctrlCfg, syncCfg;
  logic strobe, irq, badFlag;
  logic [N2*32-1:0] s2, d2, l2, c2, f2;
  logic [31:0] g2, y2;
  logic strobe2, irq2, bad2;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  dma_csr_bank #(.NUM_CHAN(N)) u_dma_csr_bank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdata), .tcEvent(tcEvent), .errEvent(errEvent),
    .chanSrc(chanSrc), .chanDst(chanDst), .chanLink(chanLink), .chanCtrl(chanCtrl),
    .chanCfg(chanCfg), .ctrlCfg(ctrlCfg), .syncCfg(syncCfg),
    .cfgWrStrobe(strobe), .irq(irq), .badFlag(badFlag)
  );

  dma_csr_bank #(.NUM_CHAN(N2)) u_dma_csr_bank_two (
    .clk(clk), .rstN(rstN), .busSel(selTwo), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdata2), .tcEvent('0), .errEvent('0),
    .chanSrc(s2), .chanDst(d2), .chanLink(l2), .chanCtrl(c2),
    .chanCfg(f2), .ctrlCfg(g2), .syncCfg(y2),
    .cfgWrStrobe(strobe2), .irq(irq2), .badFlag(bad2)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit two, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = !two; selTwo = two; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; selTwo = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input bit two, input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    busSel = !two; selTwo = two; busWr = 1'b0; busAddr = a;
    #2 v = two ? rdata2 : rdata;
    @(negedge clk);
    busSel = 1'b0; selTwo = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(1'b0, a, v);
    check(req, v, exp);
  endtask

  task automatic pulseEv(input logic [N-1:0] tc, input logic [N-1:0] er);
    @(negedge clk);
    tcEvent = tc; errEvent = er;
    @(negedge clk);
    tcEvent = '0; errEvent = '0;
  endtask

  task automatic tReset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 badFlag", {31'b0, badFlag}, 32'h0);
    rdChk("R1 status", 12'h000, 32'h0);
    rdChk("R1 raw tc", 12'h014, 32'h0);
    rdChk("R1 chan cfg", 12'h110, 32'h0);
    check("R1 ctrlCfg", ctrlCfg, 32'h0);
  endtask

  task automatic tChanRegs();
    int chs[3] = '{0, 3, 7};
    foreach (chs[i]) begin
      for (int s = 0; s < 5; s++)
        wr(1'b0, 12'(32'h100 + 32'h20 * chs[i] + 4 * s), 32'hA000_0000 | (chs[i] << 8) | s);
    end
    foreach (chs[i]) begin
      for (int s = 0; s < 5; s++)
        rdChk("R2 readback", 12'(32'h100 + 32'h20 * chs[i] + 4 * s), 32'hA000_0000 | (chs[i] << 8) | s);
    end
    check("R2 src port ch3", chanSrc[3*32 +: 32], 32'hA000_0300);
    check("R2 cfg port ch7", chanCfg[7*32 +: 32], 32'hA000_0704);
    check("R2 link port ch0", chanLink[0 +: 32], 32'hA000_0002);
    for (int c = 0; c < N; c++) wr(1'b0, 12'(32'h110 + 32'h20 * c), 32'h0);
  endtask

  task automatic tStatus();
    pulseEv(8'h0A, 8'h30);
    rdChk("R3 raw tc set", 12'h014, 32'h0A);
    rdChk("R3 raw err set", 12'h018, 32'h30);
    wr(1'b0, 12'h008, 32'h02);
    rdChk("R3 tc clear", 12'h014, 32'h08);
    // same-cycle set and clear on bit 3
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 12'h008; busWdata = 32'hFFFF_FFFF; tcEvent = 8'h08;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; tcEvent = '0;
    rdChk("R3 set wins", 12'h014, 32'h08);
    wr(1'b0, 12'h008, 32'h08);
    rdChk("R3 tc cleared", 12'h014, 32'h0);
    wr(1'b0, 12'h010, 32'h10);
    rdChk("R3 err clear", 12'h018, 32'h20);
  endtask

  task automatic tMaskIrq();
    check("R5 irq masked off", {31'b0, irq}, 32'h0);
    rdChk("R4 masked err none", 12'h00C, 32'h0);
    wr(1'b0, 12'h1B0, 32'h0000_4000);
    #1 check("R5 irq on err mask", {31'b0, irq}, 32'h1);
    rdChk("R4 masked err", 12'h00C, 32'h20);
    pulseEv(8'h04, 8'h00);
    wr(1'b0, 12'h150, 32'h0000_8000);
    rdChk("R4 masked tc", 12'h004, 32'h04);
    rdChk("R4 combined", 12'h000, 32'h24);
    wr(1'b0, 12'h010, 32'h20);
    #1 check("R5 irq held by tc", {31'b0, irq}, 32'h1);
    wr(1'b0, 12'h008, 32'h04);
    #1 check("R5 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic tEnable();
    wr(1'b0, 12'h130, 32'h1);
    wr(1'b0, 12'h1D0, 32'h8001);
    rdChk("R6 enable map", 12'h01C, 32'h42);
  endtask

  task automatic tGlobal();
    wr(1'b0, 12'h030, 32'h7);
    wr(1'b0, 12'h034, 32'h1234);
    rdChk("R7 ctrl cfg", 12'h030, 32'h7);
    rdChk("R7 sync", 12'h034, 32'h1234);
    check("R7 ctrlCfg port", ctrlCfg, 32'h7);
    check("R7 syncCfg port", syncCfg, 32'h1234);
    wr(1'b0, 12'h024, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) rdChk("R7 soft req zero", 12'(32'h020 + 4 * k), 32'h0);
    rdChk("R7 sync untouched", 12'h034, 32'h1234);
    check("R7 soft req not bad", {31'b0, badFlag}, 32'h0);
  endtask

  task automatic tStrobe();
    wr(1'b0, 12'h170, 32'h0);
    #1 check("R8 strobe chan cfg", {31'b0, strobe}, 32'h1);
    @(negedge clk);
    #1 check("R8 strobe one cycle", {31'b0, strobe}, 32'h0);
    wr(1'b0, 12'h034, 32'h5);
    #1 check("R8 no strobe on sync", {31'b0, strobe}, 32'h0);
    wr(1'b0, 12'h16C, 32'h5);
    #1 check("R8 no strobe on ctrl word", {31'b0, strobe}, 32'h0);
    wr(1'b0, 12'h030, 32'h1);
    #1 check("R8 strobe global cfg", {31'b0, strobe}, 32'h1);
  endtask

  task automatic tIdent();
    logic [7:0] ids[8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++) rdChk("R9 id byte", 12'(32'hFE0 + 4 * k), {24'h0, ids[k]});
  endtask

  task automatic tBad();
    check("R10 flag clear before", {31'b0, badFlag}, 32'h0);
    rdChk("R10 slot 5 reads zero", 12'h114, 32'h0);
    check("R10 flag set", {31'b0, badFlag}, 32'h1);
    wr(1'b0, 12'h114, 32'hDEAD_BEEF);
    rdChk("R10 neighbour kept", 12'h110, 32'h0);
    rdChk("R10 next chan kept", 12'h120, 32'h0);
    wr(1'b0, 12'h014, 32'hFF);
    rdChk("R10 ro write ignored", 12'h014, 32'h0);
    rdChk("R10 undefined offset", 12'h040, 32'h0);
    rdChk("R10 clear offset read", 12'h008, 32'h0);
    check("R10 flag sticky", {31'b0, badFlag}, 32'h1);
  endtask

  task automatic tSmall();
    logic [31:0] v;
    rd(1'b1, 12'hFE0, v);
    check("R9 two-channel id", v, 32'h81);
    check("R10 small flag clear", {31'b0, bad2}, 32'h0);
    wr(1'b1, 12'h150, 32'h8001);
    #1 check("R10 no strobe on bad", {31'b0, strobe2}, 32'h0);
    rd(1'b1, 12'h150, v);
    check("R10 chan beyond count", v, 32'h0);
    rd(1'b1, 12'h01C, v);
    check("R10 bad write ignored", v, 32'h0);
    check("R10 small flag set", {31'b0, bad2}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tChanRegs();
    tStatus();
    tMaskIrq();
    tEnable();
    tGlobal();
    tStrobe();
    tIdent();
    tBad();
    tSmall();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule